// File: doc/BRIEF.md
# Tile-Order Byte Line Copier

This block moves one line of bytes between two regions of a byte-wide memory. Either end can be held in tiled order instead of plain linear order. A tile covers 512 bytes, laid out as 64 bytes across and 8 rows down. Inside a tile, tiled order differs from linear order only in a fixed shuffle of address bits 4 through 8. Every other address bit keeps its value.

A transfer starts with a one-cycle `start` pulse. The pulse carries the source base, the destination base, the byte count and a mode. The mode says which end, if any, is tiled. For each linear index i, from 0 to count-1, the block reads one byte and then writes it through a single memory port. Each strobe is held until `mem_ack` is sampled high. A one-cycle `done` pulse follows the last write. The address mapping is its own small module. It carries an inverse mapping used as a built-in consistency check.

Top module: `bls_line_copier`

## Requirements
- R1: The tile mapping T(a) sets bit 4 to a[6], bit 5 to a[4], bits 7:6 to a[8:7] and bit 8 to a[5]. All other bits of T(a) equal those of a.
- R2: In mode 0 (linear to linear), byte i is read from src_base+i and written to dst_base+i.
- R3: In mode 1 (tiled source), byte i is read from T(src_base+i) and written to dst_base+i.
- R4: In mode 2 (tiled destination), byte i is read from src_base+i and written to T(dst_base+i).
- R5: Each byte is a read, then a write. A strobe and its address stay unchanged until a cycle with `mem_ack` high. The written byte is the one returned on the accepted read.
- R6: Exactly `length` bytes are moved, in ascending order of i, and there is no memory access outside a transfer.
- R7: `busy` is high from the cycle after an accepted start until the final write is acknowledged. `done` is high for exactly one cycle, the cycle after that acknowledgement.
- R8: A start with length 0 makes no memory access and raises `done` in the cycle after the start.
- R9: A start with mode 3 is ignored: no access, no `busy`, no `done`.
- R10: A start that arrives while `busy` or `done` is high is ignored. The running transfer is unaffected.
- R11: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R12: A mode 2 transfer followed by a mode 1 transfer, both using the same tiled base and length, reproduces the original linear bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| mode | input | 2 | 0 linear copy, 1 tiled source, 2 tiled destination, 3 reserved |
| src_base | input | ADDR_W | Source base byte address |
| dst_base | input | ADDR_W | Destination base byte address |
| length | input | LEN_W | Number of bytes to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write byte |
| mem_rdata | input | DATA_W | Read byte, valid while `mem_ack` is high on a read |
| mem_ack | input | 1 | Memory accepts the current strobe |

## Verification
The bench runs three line patterns, one per mode:
- An unaligned linear copy, which separates plain offsets from any shuffle.
- A full aligned tile read in tiled order from a base with high bits set. Every in-tile bit combination is visited, and bits above the tile have to pass through unchanged.
- An unaligned tiled-destination line that crosses a tile edge, which exposes carries into the shuffled field.

A round trip through a misaligned tiled region tells a correct inverse pairing apart from a mapping that is merely consistent in one direction. Random acknowledge stalls separate strobe holding from a design that simply advances every cycle. Zero length, the reserved mode and a start issued mid-transfer cover the three ways a start must leave the port quiet.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int PERM_LO = 4;
    localparam int PERM_HI = 8;
    localparam int PERM_W  = PERM_HI - PERM_LO + 1;

    typedef enum logic [1:0] {
        XFER_FLAT        = 2'd0,
        XFER_TILE_TO_LIN = 2'd1,
        XFER_LIN_TO_TILE = 2'd2,
        XFER_RSVD        = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_FIN
    } copy_state_e;

    // index 0 is address bit 4, index 4 is address bit 8
    function automatic logic [PERM_W-1:0] perm_fwd(input logic [PERM_W-1:0] b);
        return {b[1], b[4:3], b[0], b[2]};
    endfunction

    function automatic logic [PERM_W-1:0] perm_inv(input logic [PERM_W-1:0] o);
        return {o[3:2], o[0], o[4], o[1]};
    endfunction

endpackage

// File: rtl/bls_perm.sv
module bls_perm
    import bls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lin_addr,
    output logic [ADDR_W-1:0] tile_addr
);

    localparam int UPPER_W = ADDR_W - PERM_HI - 1;

    logic [PERM_W-1:0] field_in;
    logic [PERM_W-1:0] field_out;

    assign field_in  = lin_addr[PERM_HI:PERM_LO];
    assign field_out = perm_fwd(field_in);

    generate
        if (UPPER_W > 0) begin : g_upper
            assign tile_addr = {lin_addr[ADDR_W-1:PERM_HI+1], field_out, lin_addr[PERM_LO-1:0]};
        end else begin : g_no_upper
            assign tile_addr = {field_out, lin_addr[PERM_LO-1:0]};
        end
    endgenerate

    always_comb begin
        // R1
        perm_roundtrip_chk: assert (perm_inv(tile_addr[PERM_HI:PERM_LO]) == lin_addr[PERM_HI:PERM_LO]);
        // R1
        perm_low_keep_chk: assert (tile_addr[PERM_LO-1:0] == lin_addr[PERM_LO-1:0]);
    end

endmodule

// File: rtl/bls_addr_gen.sv
module bls_addr_gen
    import bls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  xfer_mode_e        mode,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  length,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              last
);

    localparam int SIDES = 2;

    xfer_mode_e        mode_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] base_q [SIDES];
    logic [ADDR_W-1:0] lin    [SIDES];
    logic [ADDR_W-1:0] swz    [SIDES];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= XFER_FLAT;
            idx_q     <= '0;
            len_q     <= '0;
            base_q[0] <= '0;
            base_q[1] <= '0;
        end else if (load) begin
            mode_q    <= mode;
            idx_q     <= '0;
            len_q     <= length;
            base_q[0] <= src_base;
            base_q[1] <= dst_base;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_side
            assign lin[s] = base_q[s] + ADDR_W'(idx_q);
            bls_perm #(.ADDR_W(ADDR_W)) u_perm (
                .lin_addr (lin[s]),
                .tile_addr(swz[s])
            );
        end
    endgenerate

    assign rd_addr = (mode_q == XFER_TILE_TO_LIN) ? swz[0] : lin[0];
    assign wr_addr = (mode_q == XFER_LIN_TO_TILE) ? swz[1] : lin[1];
    assign last    = (idx_q == len_q - 1'b1);

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (idx_q == $past(idx_q) + 1'b1));
    // R6
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx_q == '0));

endmodule

// File: rtl/bls_line_copier.sv
module bls_line_copier
    import bls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  length,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    copy_state_e       state;
    xfer_mode_e        mode_in;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              advance;
    logic              last;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;

    assign mode_in = xfer_mode_e'(mode);
    assign accept  = (state == ST_IDLE) && start && (mode_in != XFER_RSVD);
    assign advance = (state == ST_WR) && mem_ack && !last;

    bls_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr_gen (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .advance (advance),
        .mode    (mode_in),
        .src_base(src_base),
        .dst_base(dst_base),
        .length  (length),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= (length == '0) ? ST_FIN : ST_RD;
                ST_RD: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= ST_WR;
                    end
                end
                ST_WR:   if (mem_ack) state <= last ? ST_FIN : ST_RD;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd    = (state == ST_RD);
    assign mem_wr    = (state == ST_WR);
    assign mem_addr  = mem_rd ? rd_addr : wr_addr;
    assign mem_wdata = data_q;
    assign busy      = mem_rd || mem_wr;
    assign done      = (state == ST_FIN);

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && mode == 2'd3) |=> (!busy && !done));
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack && start) |=> $stable(mem_addr));

endmodule

// File: tb/bls_line_copier_bench.sv
`timescale 1ns/1ps
module bls_line_copier_bench;

    localparam int AW = 32;
    localparam int LW = 16;

    typedef struct packed {
        bit          wr;
        logic [31:0] addr;
    } txn_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] dst_base = '0;
    logic [LW-1:0] length = '0;
    logic          busy, done, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;
    logic          mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    bls_line_copier #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(8)) u_bls_line_copier (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .src_base(src_base), .dst_base(dst_base), .length(length),
        .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #2 clk = ~clk;

    logic [7:0] mem [int unsigned];

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] ref_swz(input logic [31:0] a);
        return (a & ~32'h1F0) | ((a & 32'h40) >> 2) | ((a & 32'h10) << 1)
             | ((a & 32'h180) >> 1) | ((a & 32'h20) << 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model state
    txn_t        q[$];
    bit          model_active = 0;
    bit          done_now = 0;
    bit          ack_rand = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  last_rd = 8'h00;
    int          strobe_cyc = 0;
    int          wr_acks = 0;
    int          done_cnt = 0;
    string       mode_tag = "R2";

    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            done_now = 0;
        end else begin
            bit   nxt;
            bit   was_active;
            bit   ack;
            txn_t h;
            nxt        = 0;
            was_active = model_active;
            chk(done === done_now, "R7", "done timing", done, done_now);
            chk(busy === model_active, "R7", "busy level", busy, model_active);
            if (done) done_cnt++;
            ack  = ack_rand ? (lfsr[1:0] != 2'b00) : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ack   = ack;
            mem_rdata = mem_rd ? rd_byte(mem_addr) : 8'h00;
            if (mem_rd || mem_wr) begin
                strobe_cyc++;
                chk(!(mem_rd && mem_wr), "R5", "both strobes", {mem_rd, mem_wr}, 2'b10);
                if (q.size() == 0) begin
                    chk(0, "R6", "access outside transfer", mem_addr, 0);
                end else begin
                    h = q[0];
                    chk(mem_wr == h.wr, "R5", "strobe kind", mem_wr, h.wr);
                    chk(mem_addr == h.addr, mode_tag, "address (R1 mapping)", mem_addr, h.addr);
                    if (mem_wr) chk(mem_wdata == last_rd, "R5", "write data", mem_wdata, last_rd);
                    if (ack) begin
                        if (mem_rd) begin
                            last_rd = rd_byte(mem_addr);
                        end else begin
                            mem[mem_addr] = mem_wdata;
                            wr_acks++;
                        end
                        void'(q.pop_front());
                        if (mem_wr && q.size() == 0) begin
                            model_active = 0;
                            nxt = 1;
                        end
                    end
                end
            end
            if (start && !was_active && !done_now && mode != 2'd3) begin
                mode_tag = (mode == 2'd1) ? "R3" : (mode == 2'd2) ? "R4" : "R2";
                for (int i = 0; i < int'(length); i++) begin
                    logic [31:0] sa, da;
                    sa = src_base + 32'(i);
                    da = dst_base + 32'(i);
                    if (mode == 2'd1) sa = ref_swz(sa);
                    if (mode == 2'd2) da = ref_swz(da);
                    q.push_back('{wr: 1'b0, addr: sa});
                    q.push_back('{wr: 1'b1, addr: da});
                end
                if (length == '0) nxt = 1;
                else model_active = 1;
            end
            done_now = nxt;
        end
    end

    task automatic launch(input logic [1:0] m, input logic [31:0] s,
                          input logic [31:0] d, input int n);
        @(posedge clk); #1;
        start = 1'b1; mode = m; src_base = s; dst_base = d; length = LW'(n);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit, input string req);
        int n = 0;
        while (!done && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, "completion seen", done, 1);
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog expired: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] expv [];
        int s0, w0, d0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy === 1'b0, "R11", "busy after reset", busy, 0);
        chk(done === 1'b0, "R11", "done after reset", done, 0);
        chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R11", "strobes after reset", {mem_rd, mem_wr}, 0);

        // R2 linear copy, always-ack
        ack_rand = 0;
        expv = new[20];
        for (int i = 0; i < 20; i++) expv[i] = rd_byte(32'h103 + 32'(i));
        launch(2'd0, 32'h103, 32'h8000, 20);
        wait_done(500, "R2");
        for (int i = 0; i < 20; i++)
            chk(rd_byte(32'h8000 + 32'(i)) == expv[i], "R2", "copied byte", rd_byte(32'h8000 + 32'(i)), expv[i]);

        // R3 + R1 full tile from tiled source with high bits, random stalls
        ack_rand = 1;
        expv = new[512];
        for (int i = 0; i < 512; i++) expv[i] = rd_byte(ref_swz(32'h0ABC_D000 + 32'(i)));
        launch(2'd1, 32'h0ABC_D000, 32'h9000, 512);
        wait_done(8000, "R3");
        for (int i = 0; i < 512; i++)
            chk(rd_byte(32'h9000 + 32'(i)) == expv[i], "R3", "detiled byte", rd_byte(32'h9000 + 32'(i)), expv[i]);

        // R4 tiled destination, unaligned, crossing a tile edge
        expv = new[77];
        for (int i = 0; i < 77; i++) expv[i] = rd_byte(32'h307 + 32'(i));
        launch(2'd2, 32'h307, 32'h0040_01E5, 77);
        wait_done(2000, "R4");
        for (int i = 0; i < 77; i++)
            chk(rd_byte(ref_swz(32'h0040_01E5 + 32'(i))) == expv[i], "R4", "tiled byte",
                rd_byte(ref_swz(32'h0040_01E5 + 32'(i))), expv[i]);

        // R12 round trip through a misaligned tiled region
        expv = new[100];
        for (int i = 0; i < 100; i++) expv[i] = rd_byte(32'h500B + 32'(i));
        launch(2'd2, 32'h500B, 32'h71C5, 100);
        wait_done(3000, "R12");
        launch(2'd1, 32'h71C5, 32'h6000, 100);
        wait_done(3000, "R12");
        for (int i = 0; i < 100; i++)
            chk(rd_byte(32'h6000 + 32'(i)) == expv[i], "R12", "round trip byte", rd_byte(32'h6000 + 32'(i)), expv[i]);

        // R8 zero length
        s0 = strobe_cyc; d0 = done_cnt;
        launch(2'd1, 32'h1000, 32'h2000, 0);
        wait_done(3, "R8");
        repeat (4) @(negedge clk);
        chk(strobe_cyc == s0, "R8", "no access on zero length", strobe_cyc, s0);
        chk(done_cnt == d0 + 1, "R8", "single done pulse", done_cnt, d0 + 1);

        // R9 reserved mode
        s0 = strobe_cyc; d0 = done_cnt;
        launch(2'd3, 32'h1000, 32'h2000, 8);
        repeat (12) @(negedge clk);
        chk(strobe_cyc == s0, "R9", "no access for reserved mode", strobe_cyc, s0);
        chk(done_cnt == d0, "R9", "no done for reserved mode", done_cnt, d0);
        chk(busy === 1'b0, "R9", "busy for reserved mode", busy, 0);

        // R10 start while busy is ignored
        w0 = wr_acks; d0 = done_cnt;
        launch(2'd0, 32'hA000, 32'hB000, 30);
        repeat (6) @(posedge clk);
        launch(2'd1, 32'hC000, 32'hD000, 5);
        wait_done(2000, "R10");
        launch(2'd2, 32'hC000, 32'hD000, 5);
        @(negedge clk);
        chk(busy === 1'b1, "R10", "start accepted after done", busy, 1);
        wait_done(500, "R10");
        repeat (10) @(negedge clk);
        chk(wr_acks == w0 + 35, "R10", "bytes written", wr_acks, w0 + 35);
        chk(done_cnt == d0 + 2, "R7", "done pulses", done_cnt, d0 + 2);
        chk(q.size() == 0, "R6", "all expected accesses seen", q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule